// File: doc/BRIEF.md
# Receive FIFO with Trigger Level and Idle Time-out

This block is a 16-entry, byte-wide receive queue between a data pump, which writes received bytes, and a host, which reads them. The host is not told about every byte. A single data-ready flag tells it that there is work to collect. The flag rises when the fill level reaches a chosen trigger, or when the queue holds data and nothing has moved for a chosen number of bit times. A separate not-empty flag tracks occupancy directly. Once data-ready rises, it stays up until the host has drained every byte. A short final burst that never reaches the trigger therefore still gets collected.

An 8-bit configuration register selects the trigger, the idle delay and whether the idle time-out is active. Idle time is counted in pulses of a one-cycle bit-time strobe. Any accepted write and any host read request restart the count. A write into a full queue is discarded and raises a sticky overrun flag, which a host status read clears. A read from an empty queue returns zero.

Top module: `rxfifo_trig`

## Requirements
- R1: After synchronous reset the configuration reads 0xCB, level is 0, and data_ready, not_empty and overrun are 0.
- R2: Bytes leave in the order they were accepted; up to 16 are held; `level` reports the number held; `rd_data` shows the oldest byte while not empty and is consumed at the clock edge where `rd_en` is high.
- R3: A write while 16 bytes are held and no read is requested is discarded and sets `overrun`; `overrun` stays set until a cycle with `stat_rd` high clears it.
- R4: A read request while empty returns 0x00 on `rd_data` and leaves the level at 0.
- R5: Configuration bits 7:6 code the trigger: 00 = 1, 01 = 4, 10 = 8, 11 = 14 bytes. `data_ready` is high from the edge where the level first reaches the trigger.
- R6: With bit 1 set, bits 4:2 (code n) give an idle limit of 9+4n bit-time strobes. When the queue is non-empty, `data_ready` rises at the edge that counts the limit-th strobe since the last accepted write or read request. An empty queue never raises it this way.
- R7: With bit 1 clear, idle strobes never raise `data_ready`.
- R8: Once high, `data_ready` stays high until the level returns to 0, and then drops at that same edge; `not_empty` is high exactly when the level is non-zero.
- R9: A write and a read in the same cycle on a non-empty queue leave the level unchanged and restart the idle count.
- R10: A new trigger code applies to the next comparison and does not disturb the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data pump write strobe |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Host read request |
| rd_data | output | 8 | Oldest stored byte, 0x00 when empty |
| bit_tick | input | 1 | One-cycle bit-time strobe for the idle counter |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration value to write |
| cfg_rdata | output | 8 | Current configuration value |
| stat_rd | input | 1 | Host status read; clears overrun |
| data_ready | output | 1 | Latched service request |
| not_empty | output | 1 | Queue holds at least one byte |
| overrun | output | 1 | Sticky lost-write flag |
| level | output | 5 | Number of bytes held |

## Verification
The bench applies idle strobes up to one short of each tested limit and then one more, so a limit off by one would raise the flag early or late. It drains a queue that filled only partway past the trigger and checks that the flag holds until the last byte leaves. A design that cleared the flag when the level fell below the trigger would drop it too soon. The bench fills the queue past 16 and reads everything back. This shows the dropped byte never entered and that the queue did not wrap onto the oldest entry. It also restarts the idle count with a paired read and write, and changes the trigger with data already stored, to catch a design that flushes or ignores the new code.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int FIFO_DEPTH = 16;
    localparam int DATA_W     = 8;
    localparam int IDLE_MAX   = 37;
    localparam int IDLE_W     = $clog2(IDLE_MAX + 1);
    localparam logic [7:0] CFG_RESET = 8'hCB;

    typedef struct packed {
        logic [1:0] trig;
        logic       rsv5;
        logic [2:0] tmo;
        logic       tmo_en;
        logic       spare0;
    } rxf_cfg_t;

    function automatic logic [4:0] trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic [IDLE_W-1:0] idle_limit(input logic [2:0] code);
        return IDLE_W'(9) + IDLE_W'({code, 2'b00});
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head = mem[rp];

endmodule

// File: rtl/rxf_idle.sv
module rxf_idle #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         activity,
    input  logic         tick,
    output logic [W-1:0] idle_nxt
);

    logic [W-1:0] idle_q;

    always_comb begin
        if (activity)
            idle_nxt = '0;
        else if (tick && idle_q != '1)
            idle_nxt = idle_q + 1'b1;
        else
            idle_nxt = idle_q;
    end

    always_ff @(posedge clk) begin
        if (rst) idle_q <= '0;
        else     idle_q <= idle_nxt;
    end

endmodule

// File: rtl/rxfifo_trig.sv
module rxfifo_trig
    import rxf_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              bit_tick,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              stat_rd,
    output logic              data_ready,
    output logic              not_empty,
    output logic              overrun,
    output logic [CNT_W-1:0]  level
);

    rxf_cfg_t          cfg_q;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic              empty, full, rd_fire, wr_fire;
    logic [IDLE_W-1:0] idle_nxt;
    logic              idle_hit, trig_hit, ready_q, ovr_q;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign rd_fire = rd_en && !empty;
    assign wr_fire = wr_en && (!full || rd_en);
    assign cnt_nxt = cnt + CNT_W'(wr_fire) - CNT_W'(rd_fire);

    rxf_store #(.DEPTH(DEPTH), .W(DATA_W)) i_store (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_fire),
        .din   (wr_data),
        .pop   (rd_fire),
        .head  (head),
        .count (cnt)
    );

    rxf_idle #(.W(IDLE_W)) i_idle (
        .clk      (clk),
        .rst      (rst),
        .activity (wr_fire || rd_en),
        .tick     (bit_tick),
        .idle_nxt (idle_nxt)
    );

    assign idle_hit = cfg_q.tmo_en && (idle_nxt >= idle_limit(cfg_q.tmo));
    assign trig_hit = (cnt_nxt >= CNT_W'(trig_level(cfg_q.trig)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= rxf_cfg_t'(CFG_RESET);
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (cfg_we) cfg_q <= rxf_cfg_t'(cfg_wdata);
            ready_q <= (cnt_nxt != '0) && (ready_q || trig_hit || idle_hit);
            if (wr_en && !wr_fire) ovr_q <= 1'b1;
            else if (stat_rd)      ovr_q <= 1'b0;
        end
    end

    assign rd_data    = empty ? '0 : head;
    assign cfg_rdata  = cfg_q;
    assign data_ready = ready_q;
    assign not_empty  = !empty;
    assign overrun    = ovr_q;
    assign level      = cnt;

endmodule

// File: rtl/rxfifo_trig_chk.sv
module rxfifo_trig_chk
    import rxf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] cfg_rdata,
    input logic [4:0] level,
    input logic       data_ready,
    input logic       not_empty,
    input logic       overrun
);

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        level <= 5'(FIFO_DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (level == 5'(FIFO_DEPTH) && wr_en && !rd_en) |=> (overrun && level == 5'(FIFO_DEPTH)));

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
        (level == 5'd0 && rd_en && !wr_en) |=> (level == 5'd0));

    assert_trigger_R5: assert property (@(posedge clk) disable iff (rst)
        (level >= trig_level(cfg_rdata[7:6]) && $stable(cfg_rdata)) |-> data_ready);

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(data_ready) |-> (level == 5'd0));

    assert_ready_flag_R8: assert property (@(posedge clk) disable iff (rst)
        data_ready |-> not_empty);

    assert_pair_level_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && level != 5'd0) |=> $stable(level));

endmodule

bind rxfifo_trig rxfifo_trig_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .cfg_rdata  (cfg_rdata),
    .level      (level),
    .data_ready (data_ready),
    .not_empty  (not_empty),
    .overrun    (overrun)
);

// File: tb/test_rxfifo_trig.sv
module test_rxfifo_trig;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, bit_tick = 1'b0;
    logic       cfg_we = 1'b0, stat_rd = 1'b0;
    logic [7:0] wr_data = '0, cfg_wdata = '0;
    logic [7:0] rd_data, cfg_rdata;
    logic       data_ready, not_empty, overrun;
    logic [4:0] level;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    rxfifo_trig i_rxfifo_trig (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .bit_tick(bit_tick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .stat_rd(stat_rd), .data_ready(data_ready),
        .not_empty(not_empty), .overrun(overrun), .level(level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        if (exp_q.size() < 16) exp_q.push_back(d);
        cyc();
        wr_en = 1'b0;
    endtask

    // monitor side of the scoreboard: compare head against the oldest expected byte
    task automatic pop(input string req);
        logic [7:0] e;
        e = (exp_q.size() == 0) ? 8'h00 : exp_q.pop_front();
        check(rd_data == e, req, rd_data, e);
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; cyc(); bit_tick = 1'b0;
        end
    endtask

    task automatic set_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v; cyc(); cfg_we = 1'b0;
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) pop(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(); cyc(); rst = 1'b0; cyc();
        // R1 reset state
        check(cfg_rdata == 8'hCB, "R1 cfg", cfg_rdata, 8'hCB);
        check(level == 0 && !not_empty, "R1 level", level, 0);
        check(!data_ready && !overrun, "R1 flags", {data_ready, overrun}, 0);

        // R4 empty read
        pop("R4 empty data");
        check(level == 0, "R4 level", level, 0);

        // R5 trigger 1 byte, timeout off
        set_cfg(8'h00);
        push(8'h11);
        check(data_ready == 1, "R5 trig1", data_ready, 1);
        drain("R2 order");
        check(data_ready == 0, "R8 drop at empty", data_ready, 0);

        // R5 trigger 4, R8 latch while draining
        set_cfg(8'h40);
        for (int i = 0; i < 3; i++) push(8'h20 + 8'(i));
        check(data_ready == 0, "R5 trig4 below", data_ready, 0);
        push(8'h23);
        check(data_ready == 1, "R5 trig4 reached", data_ready, 1);
        for (int i = 0; i < 3; i++) pop("R2 order");
        check(data_ready == 1 && not_empty, "R8 held with 1 left", data_ready, 1);
        pop("R2 order");
        check(data_ready == 0 && !not_empty, "R8 cleared", data_ready, 0);

        // R5 trigger 8 and 14
        set_cfg(8'h80);
        for (int i = 0; i < 7; i++) push(8'h30 + 8'(i));
        check(data_ready == 0, "R5 trig8 below", data_ready, 0);
        push(8'h37);
        check(data_ready == 1, "R5 trig8 reached", data_ready, 1);
        drain("R2 order");
        set_cfg(8'hC0);
        for (int i = 0; i < 13; i++) push(8'h40 + 8'(i));
        check(data_ready == 0, "R5 trig14 below", data_ready, 0);
        push(8'h4D);
        check(data_ready == 1 && level == 14, "R5 trig14 reached", level, 14);
        drain("R2 order");

        // R10 trigger change keeps contents
        for (int i = 0; i < 8; i++) push(8'h50 + 8'(i));
        check(data_ready == 0, "R10 before change", data_ready, 0);
        set_cfg(8'h80);
        cyc();
        check(data_ready == 1 && level == 8, "R10 after change", level, 8);
        drain("R10 contents");

        // R2/R3 fill, overrun, sticky, clear
        set_cfg(8'hC0);
        for (int i = 0; i < 16; i++) push(8'h60 + 8'(i));
        check(level == 16 && !overrun, "R2 full", level, 16);
        push(8'hEE);
        check(level == 16 && overrun, "R3 dropped", level, 16);
        cyc();
        check(overrun == 1, "R3 sticky", overrun, 1);
        stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
        check(overrun == 0, "R3 cleared", overrun, 0);
        drain("R3 no overwrite");

        // R7 timeout disabled
        push(8'h71);
        ticks(50);
        check(data_ready == 0, "R7 disabled", data_ready, 0);
        drain("R2 order");

        // R6 limit 17 (code 2), only when non-empty
        set_cfg(8'hCA);
        ticks(40);
        check(data_ready == 0, "R6 empty no ready", data_ready, 0);
        push(8'h81);
        ticks(16);
        check(data_ready == 0, "R6 16 of 17", data_ready, 0);
        ticks(1);
        check(data_ready == 1, "R6 17 of 17", data_ready, 1);
        drain("R2 order");
        check(data_ready == 0, "R8 cleared after timeout", data_ready, 0);

        // R6 limit 37 (code 7)
        set_cfg(8'hDE);
        push(8'h91);
        ticks(36);
        check(data_ready == 0, "R6 36 of 37", data_ready, 0);
        ticks(1);
        check(data_ready == 1, "R6 37 of 37", data_ready, 1);
        drain("R2 order");

        // R9 paired access restarts idle, keeps level (limit 9)
        set_cfg(8'hC2);
        push(8'hA0); push(8'hA1);
        ticks(8);
        check(data_ready == 0, "R9 8 of 9", data_ready, 0);
        begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(rd_data == e, "R9 head", rd_data, e);
            exp_q.push_back(8'hA2);
            wr_en = 1'b1; wr_data = 8'hA2; rd_en = 1'b1;
            cyc();
            wr_en = 1'b0; rd_en = 1'b0;
        end
        check(level == 2, "R9 level kept", level, 2);
        ticks(8);
        check(data_ready == 0, "R9 idle restarted", data_ready, 0);
        ticks(1);
        check(data_ready == 1, "R6 limit 9", data_ready, 1);
        drain("R9 order");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule